// File: doc/BRIEF.md
# Micro-TLB Context Binding Table

This block holds one small configuration entry for each micro-TLB in a translation unit, where each micro-TLB serves a single bus-master port. An entry records three things: whether translation is enabled for that port, which translation context the port is bound to, and an address-space identifier. Software programs the entries through a simple 32-bit register bus. The translation datapath reads an entry's enable and context back through a separate lookup port, indexed by micro-TLB number.

The register space is split into two windows that are not next to each other. The first 32 micro-TLBs sit in the lower window and the rest sit in the upper window. Each micro-TLB has its own 16-byte slot. Within a slot, the control word is at offset 0 and the identifier word is at offset 8.

When software writes a control word with the flush bit set, the block raises a one-cycle pulse on that micro-TLB's flush line. The flush bit itself is never stored.

Top module: `ubind_table`

## Requirements
- R1: After reset every entry is disabled, bound to context 0 and has identifier 0. Reads of any control or identifier word return 0, and every lookup returns enable 0 and context 0.
- R2: The control word of micro-TLB n (n < 32) is at byte address 0x300 + 16·n. Its identifier word is at that address + 8.
- R3: For n ≥ 32, up to the parameter count (48 by default), the control word of micro-TLB n is at byte address 0x600 + 16·(n−32). Its identifier word is at that address + 8.
- R4: The identifier word keeps bits 7:0 of a write. Those bits read back in bits 7:0, and all other bits read as 0.
- R5: In the control word, bit 0 is the enable and bits 6:4 are the bound context number. Other written bits are ignored, and they read back as 0.
- R6: A control-word write with bit 1 set makes flush bit n high for exactly one cycle, in the cycle after the write. All other flush bits stay low. Bit 1 is not stored and reads as 0.
- R7: Writing 0 to a control word disables the entry and unbinds it. It then reads back as 0, and its lookup returns enable 0 and context 0.
- R8: The lookup outputs are registered. One cycle after an index is presented, they give that entry's enable and context. A disabled entry, or an index at or above the micro-TLB count, returns enable 0 and context 0.
- R9: Read data is registered and appears in the cycle after the read strobe. Any address that is not a control or identifier word reads as 0. A write to such an address changes no entry and pulses no flush bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| lkIdx | input | 6 | Lookup micro-TLB index |
| lkEnable | output | 1 | Enable of the looked-up entry |
| lkCtx | output | 3 | Bound context of the looked-up entry |
| flushPulse | output | 48 | Per-micro-TLB flush pulse |

## Verification
There are three kinds of result, and each is due exactly one clock edge after its stimulus: read data after a read strobe, lookup outputs after an index, and a flush pulse after a control write. The bench drives each stimulus on a falling edge. It samples the result on the next falling edge, which falls after the single register stage. For flushes, the bench also samples one more falling edge later and expects the line to be low again. Expected values come from a shadow model in the bench, which searches its own address list to match each access.

// File: rtl/ubind_pkg.sv
package ubind_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CTRL = 2'd1,
    KIND_ASID = 2'd2
  } regKind_e;

  typedef struct packed {
    logic ctrlWr;
    logic asidWr;
    logic ctrlRd;
    logic asidRd;
  } ubindStrb_t;

endpackage

// File: rtl/ubind_decode.sv
module ubind_decode
  import ubind_pkg::*;
#(
  parameter int NUM_UTLB  = 48,
  parameter int ADDR_W    = 12,
  parameter int LO_BASE   = 'h300,
  parameter int HI_BASE   = 'h600,
  parameter int LO_COUNT  = 32,
  parameter int STRIDE_LG = 4,
  parameter int ASID_OFF  = 8,
  localparam int IDX_W    = $clog2(NUM_UTLB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ubindStrb_t        strb,
  output logic [IDX_W-1:0]  entryIdx
);

  localparam int LO_USED = (NUM_UTLB < LO_COUNT) ? NUM_UTLB : LO_COUNT;
  localparam int HI_USED = (NUM_UTLB > LO_COUNT) ? NUM_UTLB - LO_COUNT : 0;
  localparam logic [ADDR_W-1:0] LO_BASE_A = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] HI_BASE_A = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] LO_SLOTS  = ADDR_W'(LO_USED);
  localparam logic [ADDR_W-1:0] HI_SLOTS  = ADDR_W'(HI_USED);
  localparam logic [STRIDE_LG-1:0] SUB_ASID = STRIDE_LG'(ASID_OFF);

  logic [ADDR_W-1:0] loOff, hiOff, loSlot, hiSlot;
  logic [STRIDE_LG-1:0] subOff;
  logic slotHit;
  regKind_e kind;

  assign loOff  = regAddr - LO_BASE_A;
  assign hiOff  = regAddr - HI_BASE_A;
  assign loSlot = loOff >> STRIDE_LG;
  assign hiSlot = hiOff >> STRIDE_LG;

  always_comb begin
    slotHit  = 1'b0;
    entryIdx = '0;
    subOff   = '0;
    if (regAddr >= LO_BASE_A && loSlot < LO_SLOTS) begin
      slotHit  = 1'b1;
      entryIdx = IDX_W'(loSlot);
      subOff   = loOff[STRIDE_LG-1:0];
    end else if (regAddr >= HI_BASE_A && hiSlot < HI_SLOTS) begin
      slotHit  = 1'b1;
      entryIdx = IDX_W'(hiSlot + ADDR_W'(LO_COUNT));
      subOff   = hiOff[STRIDE_LG-1:0];
    end
  end

  always_comb begin
    kind = KIND_NONE;
    if (slotHit) begin
      if (subOff == '0)          kind = KIND_CTRL;
      else if (subOff == SUB_ASID) kind = KIND_ASID;
    end
  end

  assign strb.ctrlWr = regWrEn && (kind == KIND_CTRL);
  assign strb.asidWr = regWrEn && (kind == KIND_ASID);
  assign strb.ctrlRd = regRdEn && (kind == KIND_CTRL);
  assign strb.asidRd = regRdEn && (kind == KIND_ASID);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctrlWr, strb.asidWr}) && $onehot0({strb.ctrlRd, strb.asidRd}));

  // R2 R3
  strobe_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrlWr || strb.asidWr || strb.ctrlRd || strb.asidRd)
      |-> (int'(entryIdx) < NUM_UTLB));

endmodule

// File: rtl/ubind_store.sv
module ubind_store
  import ubind_pkg::*;
#(
  parameter int NUM_UTLB = 48,
  parameter int DATA_W   = 32,
  parameter int CTX_W    = 3,
  parameter int CTX_LSB  = 4,
  parameter int ASID_W   = 8,
  parameter int EN_BIT   = 0,
  parameter int FLUSH_BIT = 1,
  localparam int IDX_W   = $clog2(NUM_UTLB)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ubindStrb_t          strb,
  input  logic [IDX_W-1:0]    entryIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [IDX_W-1:0]    lkIdx,
  output logic                lkEnable,
  output logic [CTX_W-1:0]    lkCtx,
  output logic [NUM_UTLB-1:0] flushPulse
);

  logic [NUM_UTLB-1:0] enArr;
  logic [CTX_W-1:0]    ctxArr  [NUM_UTLB];
  logic [ASID_W-1:0]   asidArr [NUM_UTLB];

  logic unusedWrBits;
  assign unusedWrBits = ^wrData[DATA_W-1:ASID_W];

  for (genvar e = 0; e < NUM_UTLB; e++) begin : gEntry
    logic hitE;
    assign hitE = (entryIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enArr[e]   <= 1'b0;
        ctxArr[e]  <= '0;
        asidArr[e] <= '0;
        flushPulse[e] <= 1'b0;
      end else begin
        flushPulse[e] <= strb.ctrlWr && hitE && wrData[FLUSH_BIT];
        if (strb.ctrlWr && hitE) begin
          enArr[e]  <= wrData[EN_BIT];
          ctxArr[e] <= wrData[CTX_LSB +: CTX_W];
        end
        if (strb.asidWr && hitE) asidArr[e] <= wrData[ASID_W-1:0];
      end
    end
  end

  logic [DATA_W-1:0] ctrlWord, asidWord;
  always_comb begin
    ctrlWord = '0;
    ctrlWord[EN_BIT] = enArr[entryIdx];
    ctrlWord[CTX_LSB +: CTX_W] = ctxArr[entryIdx];
    asidWord = '0;
    asidWord[ASID_W-1:0] = asidArr[entryIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strb.ctrlRd) rdData <= ctrlWord;
    else if (strb.asidRd) rdData <= asidWord;
    else rdData <= '0;
  end

  logic lkInRange;
  assign lkInRange = (int'(lkIdx) < NUM_UTLB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkEnable <= 1'b0;
      lkCtx    <= '0;
    end else if (lkInRange && enArr[lkIdx]) begin
      lkEnable <= 1'b1;
      lkCtx    <= ctxArr[lkIdx];
    end else begin
      lkEnable <= 1'b0;
      lkCtx    <= '0;
    end
  end

  // R6
  flush_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flushPulse));

  // R6
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushPulse != '0) |-> $past(strb.ctrlWr && wrData[FLUSH_BIT]));

  // R8
  lookup_unbound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkEnable |-> (lkCtx == '0));

  // R8
  lookup_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'($past(lkIdx)) >= NUM_UTLB) |-> !lkEnable);

  // R6
  flush_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[FLUSH_BIT]);

endmodule

// File: rtl/ubind_table.sv
module ubind_table
  import ubind_pkg::*;
#(
  parameter int NUM_UTLB = 48,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CTX_W    = 3,
  parameter int ASID_W   = 8,
  localparam int IDX_W   = $clog2(NUM_UTLB)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [IDX_W-1:0]    lkIdx,
  output logic                lkEnable,
  output logic [CTX_W-1:0]    lkCtx,
  output logic [NUM_UTLB-1:0] flushPulse
);

  ubindStrb_t strb;
  logic [IDX_W-1:0] entryIdx;

  ubind_decode #(
    .NUM_UTLB(NUM_UTLB),
    .ADDR_W  (ADDR_W)
  ) decode_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb),
    .entryIdx(entryIdx)
  );

  ubind_store #(
    .NUM_UTLB(NUM_UTLB),
    .DATA_W  (DATA_W),
    .CTX_W   (CTX_W),
    .ASID_W  (ASID_W)
  ) store_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .entryIdx  (entryIdx),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .lkIdx     (lkIdx),
    .lkEnable  (lkEnable),
    .lkCtx     (lkCtx),
    .flushPulse(flushPulse)
  );

endmodule

// File: tb/ubind_table_tb.sv
module ubind_table_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  lkIdx = '0;
  logic        lkEnable;
  logic [2:0]  lkCtx;
  logic [NUM-1:0] flushPulse;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic       mEn   [NUM];
  logic [2:0] mCtx  [NUM];
  logic [7:0] mAsid [NUM];

  always #(CLK_PERIOD/2) clk = ~clk;

  ubind_table dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .lkIdx(lkIdx), .lkEnable(lkEnable), .lkCtx(lkCtx), .flushPulse(flushPulse)
  );

  function automatic logic [11:0] ctrlAddr(int n);
    if (n < 32) return 12'(12'h300 + 16 * n);
    return 12'(12'h600 + 16 * (n - 32));
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    for (int n = 0; n < NUM; n++) begin
      if (a == ctrlAddr(n)) return {25'd0, mCtx[n], 3'b000, mEn[n]};
      if (a == ctrlAddr(n) + 12'd8) return {24'd0, mAsid[n]};
    end
    return 32'd0;
  endfunction

  function automatic logic [NUM-1:0] expFlush(logic [11:0] a, logic [31:0] d);
    logic [NUM-1:0] v = '0;
    for (int n = 0; n < NUM; n++)
      if (a == ctrlAddr(n) && d[1]) v[n] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] expLook(logic [5:0] i);
    if (int'(i) >= NUM || !mEn[i]) return 4'd0;
    return {mCtx[i], 1'b1};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic modelWrite(logic [11:0] a, logic [31:0] d);
    for (int n = 0; n < NUM; n++) begin
      if (a == ctrlAddr(n)) begin mEn[n] = d[0]; mCtx[n] = d[6:4]; end
      if (a == ctrlAddr(n) + 12'd8) mAsid[n] = d[7:0];
    end
  endtask

  task automatic doWrite(logic [11:0] a, logic [31:0] d, string req);
    logic [NUM-1:0] ef;
    ef = expFlush(a, d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    check(req, 64'(flushPulse), 64'(ef));
    modelWrite(a, d);
    @(negedge clk);
    check({req, " flush width"}, 64'(flushPulse), 64'd0);
  endtask

  task automatic doRead(logic [11:0] a, string req);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, 64'(regRdData), 64'(expRead(a)));
  endtask

  task automatic doLook(logic [5:0] i, string req);
    @(negedge clk);
    lkIdx = i;
    @(negedge clk);
    check(req, 64'({lkCtx, lkEnable}), 64'(expLook(i)));
  endtask

  initial begin
    for (int n = 0; n < NUM; n++) begin mEn[n] = 0; mCtx[n] = 0; mAsid[n] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    doRead(ctrlAddr(0), "R1 ctrl0");
    doRead(ctrlAddr(47) + 12'd8, "R1 asid47");
    doLook(6'd5, "R1 lookup");
    check("R1 flush idle", 64'(flushPulse), 64'd0);
    // R2: low window boundaries
    doWrite(ctrlAddr(0), 32'h0000_0051, "R2 ctrl0 write");
    doRead(12'h300, "R2 ctrl0 read");
    doWrite(12'h4F8, 32'h0000_00A5, "R2 asid31 write");
    doRead(12'h4F8, "R2 asid31 read");
    // R3: high window boundaries
    doWrite(12'h600, 32'h0000_0071, "R3 ctrl32 write");
    doRead(12'h600, "R3 ctrl32 read");
    doLook(6'd32, "R3 lookup32");
    doWrite(12'h6F0, 32'h0000_0031, "R3 ctrl47 write");
    doLook(6'd47, "R3 lookup47");
    // R4: identifier field masking
    doWrite(ctrlAddr(10) + 12'd8, 32'hFFFF_FF3C, "R4 asid write");
    doRead(ctrlAddr(10) + 12'd8, "R4 asid read");
    // R5: ignored control bits
    doWrite(ctrlAddr(7), 32'hFFFF_FF8D, "R5 ctrl write");
    doRead(ctrlAddr(7), "R5 ctrl read");
    // R6: flush pulse and readback
    doWrite(ctrlAddr(33), 32'h0000_0023, "R6 flush write");
    doRead(ctrlAddr(33), "R6 flush bit read");
    doWrite(ctrlAddr(31), 32'h0000_0002, "R6 flush only");
    // R7: write zero unbinds
    doWrite(ctrlAddr(0), 32'h0, "R7 clear");
    doRead(ctrlAddr(0), "R7 read");
    doLook(6'd0, "R7 lookup");
    // R8: out of range and disabled lookups
    doLook(6'd48, "R8 idx48");
    doLook(6'd63, "R8 idx63");
    doLook(6'd20, "R8 disabled");
    // R9: holes
    doWrite(12'h304, 32'hFFFF_FFFF, "R9 hole write");
    doRead(12'h304, "R9 hole read");
    doWrite(12'h500, 32'h0000_0013, "R9 gap write");
    doWrite(12'h700, 32'h0000_0013, "R9 past end write");
    doRead(12'h700, "R9 past end read");
    doRead(ctrlAddr(7), "R9 entry untouched");
    // random phase
    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      int n = int'($urandom_range(NUM - 1, 0));
      int op = int'($urandom_range(5, 0));
      logic [31:0] d = $urandom();
      case (op)
        0: doWrite(ctrlAddr(n), d, "R5 R6 rand ctrl");
        1: doWrite(ctrlAddr(n) + 12'd8, d, "R4 rand asid");
        2: doRead(ctrlAddr(n), "R2 R3 rand ctrl read");
        3: doRead(ctrlAddr(n) + 12'd8, "R4 rand asid read");
        4: doLook(6'($urandom_range(63, 0)), "R8 rand lookup");
        default: begin
          logic [11:0] a = 12'($urandom());
          if (d[0]) doWrite(a, d, "R9 rand addr write");
          else doRead(a, "R9 rand addr read");
        end
      endcase
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule